// File: doc/BRIEF.md
# Synthetic Mesh Traffic Injector

This block sits at one node of a square k-by-k on-chip network under test and acts as a synthetic traffic source. On every cycle in which its output register can take a new packet, it draws a pseudo-random number and compares it against a programmable threshold out of 10^P, where P is a precision parameter. When the draw falls below the threshold, it builds a packet. The packet's destination node comes from one of several selectable traffic patterns and is placed in the address just above the block-offset bits. The packet's message class is also chosen at random.

Packets leave on a valid/ready request channel. A packet the network does not accept stays on the channel until it is taken, and no new packet is built in the meantime. A response strobe from the network feeds a starvation watchdog, which raises a sticky deadlock flag. A packet budget can cap the total number of injections. A cycle limit ends the run by raising a done flag, after which no further packets are built.

Top module: `mesh_traffic_injector`

## Requirements
- R1: After reset, reqValid, sentCount, done and deadlock are all zero.
- R2: A rate threshold of 0 never injects. A threshold of 10^P or more injects a packet on every cycle in which the output register is empty or being accepted.
- R3: With an intermediate threshold T and no backpressure, the fraction of cycles that inject is close to T/10^P.
- R4: In traffic mode 1, with x = id mod k and y = id div k, the destination is y·k + ((x + k div 2 − 1) mod k).
- R5: In traffic mode 2, the destination is (k−1−y)·k + (k−1−x).
- R6: In traffic mode 0, the destination is a random node below k·k. In traffic mode 3, the destination is the block's own node id.
- R7: reqAddr equals the destination index shifted left by BLOCK_OFS bits, with every other bit zero.
- R8: reqClass is 0, 1 or 2 and all three occur. reqIfetch is high only for class 1 (a read that is an instruction fetch), and reqWrite is high only for class 2. Class 0 is a plain read.
- R9: While reqValid is high and reqReady is low, reqValid stays high, reqAddr and reqClass hold their values and sentCount does not change. sentCount increments once for each packet built.
- R10: When fixedCount is high, generation stops once sentCount reaches maxPackets. When fixedCount is low, generation has no limit.
- R11: A no-response counter clears on respValid and otherwise counts cycles. deadlock rises on the WDOG_LIMIT-th consecutive cycle without respValid and then stays high.
- R12: done rises on the simCycles-th clock edge after reset and stays high. From that point no new packet is built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nodeId | input | NODE_BITS | Static index of this node in the mesh |
| trafficMode | input | 2 | 0 uniform, 1 tornado, 2 bit complement, 3 self |
| rateThresh | input | RATE_W | Injection threshold out of 10^P |
| fixedCount | input | 1 | Enables the packet budget |
| maxPackets | input | CNT_W | Packet budget when fixedCount is high |
| simCycles | input | CYC_W | Cycle count at which done rises |
| reqValid | output | 1 | Request packet present |
| reqReady | input | 1 | Network accepts the request |
| reqAddr | output | ADDR_W | Destination index shifted by BLOCK_OFS |
| reqClass | output | 2 | Message class 0..2 |
| reqIfetch | output | 1 | Read marked as instruction fetch |
| reqWrite | output | 1 | Write request |
| respValid | input | 1 | Response seen; clears the watchdog |
| sentCount | output | CNT_W | Packets built since reset |
| done | output | 1 | Cycle limit reached (sticky) |
| deadlock | output | 1 | Watchdog expired (sticky) |

## Verification
The in-line assertions check several properties on every cycle: a stalled packet stays stable and no new packet is counted while it waits, classes stay in range, the class flags never both rise, the budget is never exceeded, done and deadlock stay high once set, and sentCount is frozen after done. The bench scenarios cover what a single-cycle property cannot show. They sweep every node id through the deterministic patterns and compare the exact destination arithmetic, measure the injection fraction over a long window, and count exact cycles to the done and deadlock edges. They also confirm that each message class actually appears.

// File: rtl/traffic_pkg.sv
package traffic_pkg;
  typedef enum logic [1:0] {
    MODE_UNIFORM = 2'd0,
    MODE_TORNADO = 2'd1,
    MODE_BITCOMP = 2'd2,
    MODE_SELF    = 2'd3
  } trafficMode_e;

  localparam logic [1:0] CLASS_READ  = 2'd0;
  localparam logic [1:0] CLASS_FETCH = 2'd1;
  localparam logic [1:0] CLASS_WRITE = 2'd2;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic loadPkt;   // capture a freshly built packet
    logic dropValid; // accepted packet leaves, nothing replaces it
  } ctrlStrobe_t;
endpackage

// File: rtl/inj_ctrl.sv
module inj_ctrl
  import traffic_pkg::*;
#(
  parameter int PREC       = 2,
  parameter int RATE_W     = 8,
  parameter int CNT_W      = 16,
  parameter int CYC_W      = 20,
  parameter int WDOG_LIMIT = 500000,
  parameter logic [31:0] SEED = 32'hACE1_2468
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [RATE_W-1:0] rateThresh,
  input  logic             fixedCount,
  input  logic [CNT_W-1:0] maxPackets,
  input  logic [CYC_W-1:0] simCycles,
  input  logic             reqValid,
  input  logic             reqReady,
  input  logic             respValid,
  output ctrlStrobe_t      strobe,
  output logic [31:0]      rndWord,
  output logic [CNT_W-1:0] sentCount,
  output logic             done,
  output logic             deadlock
);
  localparam int RANGE = 10 ** PREC;
  localparam int WD_W  = $clog2(WDOG_LIMIT + 1);
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic [31:0]      lfsr;
  logic [31:0]      drawVal;
  logic [CYC_W-1:0] cycCnt;
  logic [WD_W-1:0]  noResp;
  logic canLoad, inject, budgetOk, gen;

  assign canLoad  = !reqValid || reqReady;
  assign drawVal  = {16'b0, lfsr[15:0]} % 32'(RANGE);
  assign inject   = drawVal < 32'(rateThresh);
  assign budgetOk = !fixedCount || (sentCount < maxPackets);
  assign gen      = canLoad && !done && budgetOk && inject;
  assign rndWord  = lfsr;

  assign strobe.loadPkt   = gen;
  assign strobe.dropValid = reqValid && reqReady && !gen;

  // one LFSR step per decision cycle; frozen while a packet stalls
  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= SEED;
    else if (canLoad)
      lfsr <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? TAPS : 32'h0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) sentCount <= '0;
    else if (gen) sentCount <= sentCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
      done   <= 1'b0;
    end else if (!done) begin
      cycCnt <= cycCnt + 1'b1;
      if ((cycCnt + 1'b1) >= simCycles) done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      noResp   <= '0;
      deadlock <= 1'b0;
    end else if (respValid) begin
      noResp <= '0;
    end else begin
      if (noResp != WD_W'(WDOG_LIMIT)) noResp <= noResp + 1'b1;
      if ((32'(noResp) + 32'd1) >= 32'(WDOG_LIMIT)) deadlock <= 1'b1;
    end
  end

  AST_STALL_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> $stable(sentCount)); // R9
  AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rstN)
    fixedCount |-> (sentCount <= maxPackets)); // R10
  AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    deadlock |=> deadlock); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R12
  AST_DONE_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(sentCount)); // R12
endmodule

// File: rtl/inj_datapath.sv
module inj_datapath
  import traffic_pkg::*;
#(
  parameter int K         = 4,
  parameter int NODE_BITS = 4,
  parameter int BLOCK_OFS = 6,
  parameter int ADDR_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [31:0]          rndWord,
  input  logic [NODE_BITS-1:0] nodeId,
  input  logic [1:0]           trafficMode,
  input  logic                 reqReady,
  output logic                 reqValid,
  output logic [ADDR_W-1:0]    reqAddr,
  output logic [1:0]           reqClass,
  output logic                 reqIfetch,
  output logic                 reqWrite
);
  localparam int NODES = K * K;

  logic [31:0] xPos, yPos, destX, destY, destIdx, classDraw;
  logic [1:0]  nextClass;

  // coordinate split: slicing when k is a power of two, divide otherwise
  generate
    if ((K & (K - 1)) == 0) begin : g_pow2
      localparam int XB = (K > 1) ? $clog2(K) : 1;
      assign xPos = 32'(nodeId) & 32'(K - 1);
      assign yPos = 32'(nodeId) >> XB;
    end else begin : g_general
      assign xPos = 32'(nodeId) % 32'(K);
      assign yPos = 32'(nodeId) / 32'(K);
    end
  endgenerate

  always_comb begin
    destX = xPos;
    destY = yPos;
    destIdx = 32'(nodeId);
    case (trafficMode_e'(trafficMode))
      MODE_UNIFORM: destIdx = {16'b0, rndWord[31:16]} % 32'(NODES);
      MODE_TORNADO: begin
        destX   = (xPos + 32'(K / 2) + 32'(K) - 32'd1) % 32'(K);
        destIdx = destY * 32'(K) + destX;
      end
      MODE_BITCOMP: begin
        destX   = 32'(K) - 32'd1 - xPos;
        destY   = 32'(K) - 32'd1 - yPos;
        destIdx = destY * 32'(K) + destX;
      end
      default: destIdx = 32'(nodeId);
    endcase
  end

  assign classDraw = {16'b0, rndWord[23:8]} % 32'd3;
  assign nextClass = classDraw[1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid  <= 1'b0;
      reqAddr   <= '0;
      reqClass  <= CLASS_READ;
      reqIfetch <= 1'b0;
      reqWrite  <= 1'b0;
    end else if (strobe.loadPkt) begin
      reqValid  <= 1'b1;
      reqAddr   <= ADDR_W'(destIdx) << BLOCK_OFS;
      reqClass  <= nextClass;
      reqIfetch <= (nextClass == CLASS_FETCH);
      reqWrite  <= (nextClass == CLASS_WRITE);
    end else if (strobe.dropValid) begin
      reqValid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqClass))); // R9
  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqClass != 2'd3)); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({reqIfetch, reqWrite}) <= 1); // R8
  AST_DEST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((reqAddr >> BLOCK_OFS) < ADDR_W'(NODES))); // R6
endmodule

// File: rtl/mesh_traffic_injector.sv
module mesh_traffic_injector
  import traffic_pkg::*;
#(
  parameter int K          = 4,
  parameter int BLOCK_OFS  = 6,
  parameter int ADDR_W     = 32,
  parameter int PREC       = 2,
  parameter int RATE_W     = 8,
  parameter int CNT_W      = 16,
  parameter int CYC_W      = 20,
  parameter int WDOG_LIMIT = 500000,
  parameter int NODE_BITS  = (K * K > 1) ? $clog2(K * K) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NODE_BITS-1:0] nodeId,
  input  logic [1:0]           trafficMode,
  input  logic [RATE_W-1:0]    rateThresh,
  input  logic                 fixedCount,
  input  logic [CNT_W-1:0]     maxPackets,
  input  logic [CYC_W-1:0]     simCycles,
  output logic                 reqValid,
  input  logic                 reqReady,
  output logic [ADDR_W-1:0]    reqAddr,
  output logic [1:0]           reqClass,
  output logic                 reqIfetch,
  output logic                 reqWrite,
  input  logic                 respValid,
  output logic [CNT_W-1:0]     sentCount,
  output logic                 done,
  output logic                 deadlock
);
  ctrlStrobe_t strobe;
  logic [31:0] rndWord;

  inj_ctrl #(
    .PREC(PREC), .RATE_W(RATE_W), .CNT_W(CNT_W), .CYC_W(CYC_W),
    .WDOG_LIMIT(WDOG_LIMIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rateThresh(rateThresh), .fixedCount(fixedCount),
    .maxPackets(maxPackets), .simCycles(simCycles), .reqValid(reqValid),
    .reqReady(reqReady), .respValid(respValid), .strobe(strobe),
    .rndWord(rndWord), .sentCount(sentCount), .done(done), .deadlock(deadlock)
  );

  inj_datapath #(
    .K(K), .NODE_BITS(NODE_BITS), .BLOCK_OFS(BLOCK_OFS), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rndWord(rndWord),
    .nodeId(nodeId), .trafficMode(trafficMode), .reqReady(reqReady),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqClass(reqClass),
    .reqIfetch(reqIfetch), .reqWrite(reqWrite)
  );
endmodule

// File: tb/mesh_traffic_injector_tb.sv
`timescale 1ns/1ps
module mesh_traffic_injector_tb;
  localparam int K = 4, OFS = 4, AW = 32, WD = 50;

  logic clk = 0, rstN = 0;
  logic [3:0] nodeId = 0;
  logic [1:0] trafficMode = 0;
  logic [7:0] rateThresh = 0;
  logic fixedCount = 0;
  logic [15:0] maxPackets = 0;
  logic [19:0] simCycles = 20'hFFFFF;
  logic reqReady = 1, respValid = 1;
  logic reqValid, reqIfetch, reqWrite, done, deadlock;
  logic [AW-1:0] reqAddr;
  logic [1:0] reqClass;
  logic [15:0] sentCount;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mesh_traffic_injector #(.K(K), .BLOCK_OFS(OFS), .ADDR_W(AW), .PREC(2),
    .RATE_W(8), .CNT_W(16), .CYC_W(20), .WDOG_LIMIT(WD)) u_dut (
    .clk(clk), .rstN(rstN), .nodeId(nodeId), .trafficMode(trafficMode),
    .rateThresh(rateThresh), .fixedCount(fixedCount), .maxPackets(maxPackets),
    .simCycles(simCycles), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqClass(reqClass), .reqIfetch(reqIfetch),
    .reqWrite(reqWrite), .respValid(respValid), .sentCount(sentCount),
    .done(done), .deadlock(deadlock));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rstN = 0;
    tick(2);
    rstN = 1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    #500000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cnt0, cnt1, cnt2, bad;
    logic [AW-1:0] held;
    // R1 reset state
    rstN = 0; tick(2);
    chk(reqValid == 0 && sentCount == 0 && done == 0 && deadlock == 0, "R1",
        {reqValid, sentCount, done, deadlock}, 0);

    // R2 threshold zero never injects
    rateThresh = 0; rstN = 1; tick(40);
    chk(sentCount == 0 && !reqValid, "R2 zero", sentCount, 0);

    // R2 full threshold injects every cycle
    rateThresh = 100; doReset(); tick(25);
    chk(sentCount == 25 && reqValid, "R2 full", sentCount, 25);

    // R3 intermediate rate
    rateThresh = 30; doReset(); tick(1000);
    chk(sentCount >= 220 && sentCount <= 380, "R3", sentCount, 300);

    // R4 tornado over all nodes, R7 address layout
    rateThresh = 100; trafficMode = 1;
    for (int id = 0; id < 16; id++) begin
      nodeId = 4'(id); doReset(); tick(1);
      chk(reqAddr == AW'((id / 4) * 4 + ((id % 4 + 1) % 4)) << OFS, "R4 R7",
          reqAddr, ((id / 4) * 4 + ((id % 4 + 1) % 4)) << OFS);
    end

    // R5 bit complement over all nodes
    trafficMode = 2;
    for (int id = 0; id < 16; id++) begin
      nodeId = 4'(id); doReset(); tick(1);
      chk(reqAddr == AW'((3 - id / 4) * 4 + (3 - id % 4)) << OFS, "R5",
          reqAddr, ((3 - id / 4) * 4 + (3 - id % 4)) << OFS);
    end

    // R6 self mode
    trafficMode = 3; nodeId = 4'd9; doReset(); tick(3);
    chk(reqAddr == AW'(9) << OFS, "R6 self", reqAddr, 9 << OFS);

    // R6 uniform range, R7 zero offset, R8 classes
    trafficMode = 0; nodeId = 4'd5; doReset();
    cnt0 = 0; cnt1 = 0; cnt2 = 0; bad = 0;
    for (int i = 0; i < 300; i++) begin
      tick(1);
      if (reqAddr >= (AW'(16) << OFS) || reqAddr[OFS-1:0] != 0) bad++;
      case (reqClass)
        2'd0: begin cnt0++; if (reqIfetch || reqWrite) bad++; end
        2'd1: begin cnt1++; if (!reqIfetch || reqWrite) bad++; end
        2'd2: begin cnt2++; if (reqIfetch || !reqWrite) bad++; end
        default: bad++;
      endcase
    end
    chk(bad == 0, "R6 R7 R8 fields", bad, 0);
    chk(cnt0 > 0 && cnt1 > 0 && cnt2 > 0, "R8 all classes", cnt0 * cnt1 * cnt2, 1);

    // R9 backpressure hold
    trafficMode = 0; reqReady = 0; doReset(); tick(1);
    held = reqAddr;
    tick(20);
    chk(reqValid && sentCount == 1 && reqAddr == held, "R9 hold", sentCount, 1);
    reqReady = 1; tick(1);
    chk(reqValid && sentCount == 2, "R9 release", sentCount, 2);

    // R10 fixed budget and unlimited mode
    fixedCount = 1; maxPackets = 5; doReset(); tick(20);
    chk(sentCount == 5 && !reqValid, "R10 fixed", sentCount, 5);
    fixedCount = 0; doReset(); tick(20);
    chk(sentCount == 20, "R10 free", sentCount, 20);

    // R12 done timing and generation stop
    simCycles = 20'd7; doReset(); tick(6);
    chk(!done, "R12 early", done, 0);
    tick(1);
    chk(done && sentCount == 7, "R12 edge", sentCount, 7);
    tick(10);
    chk(done && sentCount == 7, "R12 frozen", sentCount, 7);
    simCycles = 20'hFFFFF;

    // R11 watchdog
    respValid = 0; doReset(); tick(40);
    respValid = 1; tick(1); respValid = 0;
    tick(WD - 1);
    chk(!deadlock, "R11 cleared", deadlock, 0);
    tick(1);
    chk(deadlock, "R11 expire", deadlock, 1);
    respValid = 1; tick(10);
    chk(deadlock, "R11 sticky", deadlock, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule